// File: doc/BRIEF.md
# Hash Message Schedule Generator

This block supplies the per-round message word for a SHA-2 style compression engine. A padded message block of sixteen words is captured in one cycle. The block then presents one word per round: the first sixteen straight from the block, and every later word computed on the fly from a sliding window of the sixteen most recent words. One parameter selects the variant: 32-bit words over 64 rounds, or 64-bit words over 80 rounds.

The compression engine drives `advance` each time it consumes the current word. `roundIdx` tells it which round the presented word belongs to. Once the last round has been consumed, `done` rises and the block ignores `advance` until the next load. Round constants, the working-state update and padding are left to neighbouring logic.

Top module: `hsched_top`

## Requirements
- R1: After reset, `wordValid` and `done` are 0 and `roundIdx` is 0.
- R2: In the cycle after `loadStb` is high, `wordValid` is 1, `done` is 0, `roundIdx` is 0, and `wordOut` equals block word 0, taken from `blockIn` bits [W-1:0].
- R3: For rounds 0 to 15, `wordOut` equals block word i, which sits at `blockIn` bits [i*W +: W].
- R4: With W=32, each round i from 16 to 63 presents s1(W[i-2]) + W[i-7] + s0(W[i-15]) + W[i-16] mod 2^32. Here s0 = ror7 ^ ror18 ^ shr3 and s1 = ror17 ^ ror19 ^ shr10, where ror is a right rotate and shr is a zero-fill right shift. This variant has 64 rounds.
- R5: With W=64, the same recurrence applies mod 2^64 for rounds 16 to 79, with s0 = ror1 ^ ror8 ^ shr7 and s1 = ror19 ^ ror61 ^ shr6. This variant has 80 rounds.
- R6: While a block is active and `advance` and `loadStb` are both low, `wordOut` and `roundIdx` hold their values.
- R7: Each accepted `advance` before the last round raises `roundIdx` by exactly one.
- R8: An `advance` in the last round clears `wordValid` and sets `done`. While idle, `advance` changes neither flag, and `done` stays high until the next `loadStb`.
- R9: `loadStb` takes priority over `advance` and restarts the schedule at round 0 with the new block, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Capture `blockIn` and restart at round 0 |
| blockIn | input | 16*WORD_BITS | Sixteen block words, word i at bits [i*W +: W] |
| advance | input | 1 | Current word consumed; move to the next round |
| wordOut | output | WORD_BITS | Message word for the current round |
| roundIdx | output | 7 | Index of the current round |
| wordValid | output | 1 | A block is active and `wordOut` is meaningful |
| done | output | 1 | Last round consumed; idle until the next load |

## Verification
The bench checks both word widths side by side against a schedule it expands itself. It uses random blocks, an all-ones block and an all-zero block, so that a wrong rotate amount, a shift that fills with ones instead of zeros, or a misplaced window tap shows up as a wrong word from round 16 on. Random stall cycles catch a design that moves on without `advance` or skips a round. Extra `advance` pulses after the 32-bit run has ended catch a design that wraps the round counter or drops `done`. A reload issued together with `advance` partway through a run catches a design that lets the shift win over the load and starts the new block one word late.

// File: rtl/hsched_pkg.sv
package hsched_pkg;

  // Fixed width of the round index, wide enough for 80 rounds.
  localparam int IDX_BITS = 7;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadWin;   // capture a fresh block into the window
    logic shiftWin;  // slide the window by one word
  } schedCmd_t;

  function automatic int roundsFor(input int wordBits);
    return (wordBits == 64) ? 80 : 64;
  endfunction

endpackage

// File: rtl/hsched_ctrl.sv
module hsched_ctrl
  import hsched_pkg::*;
#(
  parameter int ROUNDS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                loadStb,
  input  logic                advance,
  output schedCmd_t           cmd,
  output logic [IDX_BITS-1:0] roundIdx,
  output logic                active,
  output logic                done
);

  localparam logic [IDX_BITS-1:0] LAST_ROUND = IDX_BITS'(ROUNDS - 1);

  logic [IDX_BITS-1:0] roundQ;
  logic                activeQ;
  logic                doneQ;
  logic                stepOk;
  logic                atLast;

  assign atLast = (roundQ == LAST_ROUND);
  assign stepOk = activeQ && advance && !loadStb;

  always_comb begin
    cmd          = '0;
    cmd.loadWin  = loadStb;
    cmd.shiftWin = stepOk && !atLast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      roundQ  <= '0;
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else if (loadStb) begin
      roundQ  <= '0;
      activeQ <= 1'b1;
      doneQ   <= 1'b0;
    end else if (stepOk) begin
      if (atLast) begin
        activeQ <= 1'b0;
        doneQ   <= 1'b1;
      end else begin
        roundQ <= roundQ + 1'b1;
      end
    end
  end

  assign roundIdx = roundQ;
  assign active   = activeQ;
  assign done     = doneQ;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && advance && !loadStb && roundQ != LAST_ROUND) |=> (roundQ == $past(roundQ) + 1'b1)); // R7

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && !advance && !loadStb) |=> $stable(roundQ)); // R6

  AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && advance && !loadStb && roundQ == LAST_ROUND) |=> (doneQ && !activeQ)); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (doneQ && !loadStb) |=> (doneQ && !activeQ)); // R8

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    loadStb |=> (activeQ && !doneQ && roundQ == '0)); // R9

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(activeQ && doneQ)); // R8

endmodule

// File: rtl/hsched_dp.sv
module hsched_dp
  import hsched_pkg::*;
#(
  parameter int WB = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  schedCmd_t        cmd,
  input  logic [16*WB-1:0] blockIn,
  output logic [WB-1:0]    wordOut
);

  localparam int DEPTH = 16;

  // Sigma amounts picked by word width.
  localparam int S0_RA = (WB == 64) ? 1  : 7;
  localparam int S0_RB = (WB == 64) ? 8  : 18;
  localparam int S0_SH = (WB == 64) ? 7  : 3;
  localparam int S1_RA = (WB == 64) ? 19 : 17;
  localparam int S1_RB = (WB == 64) ? 61 : 19;
  localparam int S1_SH = (WB == 64) ? 6  : 10;

  function automatic logic [WB-1:0] rotr(input logic [WB-1:0] x, input int n);
    return (x >> n) | (x << (WB - n));
  endfunction

  logic [WB-1:0] win [DEPTH];
  logic [WB-1:0] sigLo;
  logic [WB-1:0] sigHi;
  logic [WB-1:0] newWord;

  // win[k] holds W(i+k) for current round i.
  generate
    if (WB == 32 || WB == 64) begin : g_sigma
      assign sigLo = rotr(win[1], S0_RA) ^ rotr(win[1], S0_RB) ^ (win[1] >> S0_SH);
      assign sigHi = rotr(win[14], S1_RA) ^ rotr(win[14], S1_RB) ^ (win[14] >> S1_SH);
    end else begin : g_bad_width
      initial $error("hsched_dp: word width must be 32 or 64");
      assign sigLo = '0;
      assign sigHi = '0;
    end
  endgenerate

  assign newWord = sigHi + win[9] + sigLo + win[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) win[k] <= '0;
    end else if (cmd.loadWin) begin
      for (int k = 0; k < DEPTH; k++) win[k] <= blockIn[k*WB +: WB];
    end else if (cmd.shiftWin) begin
      for (int k = 0; k < DEPTH - 1; k++) win[k] <= win[k+1];
      win[DEPTH-1] <= newWord;
    end
  end

  assign wordOut = win[0];

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.loadWin |=> (wordOut == $past(blockIn[WB-1:0]))); // R2

  AST_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.shiftWin && !cmd.loadWin) |=> (wordOut == $past(win[1]))); // R3

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd.shiftWin && !cmd.loadWin) |=> $stable(wordOut)); // R6

endmodule

// File: rtl/hsched_top.sv
module hsched_top
  import hsched_pkg::*;
#(
  parameter int WORD_BITS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loadStb,
  input  logic [16*WORD_BITS-1:0] blockIn,
  input  logic                    advance,
  output logic [WORD_BITS-1:0]    wordOut,
  output logic [IDX_BITS-1:0]     roundIdx,
  output logic                    wordValid,
  output logic                    done
);

  localparam int ROUNDS = roundsFor(WORD_BITS);

  schedCmd_t cmd;

  hsched_ctrl #(.ROUNDS(ROUNDS)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadStb  (loadStb),
    .advance  (advance),
    .cmd      (cmd),
    .roundIdx (roundIdx),
    .active   (wordValid),
    .done     (done)
  );

  hsched_dp #(.WB(WORD_BITS)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .blockIn (blockIn),
    .wordOut (wordOut)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!wordValid && !done && roundIdx == '0)); // R1

endmodule

// File: tb/hsched_top_tb_top.sv
module hsched_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loadStb = 1'b0;
  logic advance = 1'b0;
  logic [16*32-1:0] blk32 = '0;
  logic [16*64-1:0] blk64 = '0;

  logic [31:0] wordA;
  logic [63:0] wordB;
  logic [6:0]  idxA, idxB;
  logic        validA, validB, doneA, doneB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] exp32 [80];
  logic [63:0] exp64 [80];

  always #10 clk = ~clk;

  hsched_top #(.WORD_BITS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .loadStb(loadStb), .blockIn(blk32), .advance(advance),
    .wordOut(wordA), .roundIdx(idxA), .wordValid(validA), .done(doneA));

  hsched_top #(.WORD_BITS(64)) dut64_i (
    .clk(clk), .rst_n(rst_n), .loadStb(loadStb), .blockIn(blk64), .advance(advance),
    .wordOut(wordB), .roundIdx(idxB), .wordValid(validB), .done(doneB));

  function automatic logic [31:0] ror32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  task automatic expand();
    for (int i = 0; i < 16; i++) begin
      exp32[i] = blk32[i*32 +: 32];
      exp64[i] = blk64[i*64 +: 64];
    end
    for (int i = 16; i < 80; i++) begin
      exp32[i] = (ror32(exp32[i-2], 17) ^ ror32(exp32[i-2], 19) ^ (exp32[i-2] >> 10))
               + exp32[i-7]
               + (ror32(exp32[i-15], 7) ^ ror32(exp32[i-15], 18) ^ (exp32[i-15] >> 3))
               + exp32[i-16];
      exp64[i] = (ror64(exp64[i-2], 19) ^ ror64(exp64[i-2], 61) ^ (exp64[i-2] >> 6))
               + exp64[i-7]
               + (ror64(exp64[i-15], 1) ^ ror64(exp64[i-15], 8) ^ (exp64[i-15] >> 7))
               + exp64[i-16];
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Check both instances at round r (r counts accepted advances since load).
  task automatic checkAt(input int r);
    string t32, t64;
    t32 = (r < 16) ? "R3" : "R4";
    t64 = (r < 16) ? "R3" : "R5";
    if (r < 64) begin
      check(validA && !doneA, "R8 valid32", {62'd0, validA, doneA}, 64'd2);
      check(wordA == exp32[r], t32, {32'd0, wordA}, {32'd0, exp32[r]});
      check(idxA == 7'(r), "R7 idx32", {57'd0, idxA}, 64'(r));
    end else begin
      check(!validA && doneA, "R8 done32", {62'd0, validA, doneA}, 64'd1);
    end
    if (r < 80) begin
      check(validB && !doneB, "R8 valid64", {62'd0, validB, doneB}, 64'd2);
      check(wordB == exp64[r], t64, wordB, exp64[r]);
      check(idxB == 7'(r), "R7 idx64", {57'd0, idxB}, 64'(r));
    end else begin
      check(!validB && doneB, "R8 done64", {62'd0, validB, doneB}, 64'd1);
    end
  endtask

  task automatic doLoad(input bit withAdv);
    expand();
    loadStb = 1'b1;
    advance = withAdv;
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    advance = 1'b0;
    check(validA && idxA == 0 && wordA == blk32[31:0], "R2 load32", {32'd0, wordA}, {32'd0, blk32[31:0]});
    check(validB && idxB == 0 && wordB == blk64[63:0], "R2 load64", wordB, blk64[63:0]);
  endtask

  task automatic runRounds(input int stallPct);
    int r = 0;
    while (r <= 80) begin
      checkAt(r);
      advance = (($urandom % 100) >= stallPct) ? 1'b1 : 1'b0;
      @(posedge clk);
      if (advance) r++;
      @(negedge clk);
    end
    advance = 1'b0;
    // Idle: further advances are ignored (R8)
    advance = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    advance = 1'b0;
    check(doneA && !validA && doneB && !validB, "R8 idle", {60'd0, doneA, validA, doneB, validB}, 64'b1010);
  endtask

  task automatic randomBlocks();
    for (int k = 0; k < 16; k++) begin
      blk32[k*32 +: 32] = $urandom;
      blk64[k*64 +: 64] = {$urandom, $urandom};
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(!validA && !doneA && idxA == 0, "R1 reset32", {55'd0, idxA, validA, doneA}, 64'd0);
    check(!validB && !doneB && idxB == 0, "R1 reset64", {55'd0, idxB, validB, doneB}, 64'd0);

    // Advance before any load is ignored (R8)
    advance = 1'b1;
    @(posedge clk);
    @(negedge clk);
    advance = 1'b0;
    check(!validA && !doneA && !validB && !doneB, "R8 never loaded", {60'd0, validA, doneA, validB, doneB}, 64'd0);

    // Directed: all ones
    blk32 = '1;
    blk64 = '1;
    doLoad(1'b0);
    runRounds(0);

    // Directed: all zero, with stalls (R6)
    blk32 = '0;
    blk64 = '0;
    doLoad(1'b0);
    runRounds(30);

    // Random blocks, with and without stalls
    for (int n = 0; n < 4; n++) begin
      randomBlocks();
      doLoad(1'b0);
      runRounds((n % 2) ? 40 : 0);
    end

    // Mid-run reload together with advance (R9)
    randomBlocks();
    doLoad(1'b0);
    advance = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(idxA == 7'd20 && idxB == 7'd20, "R7 mid run", {57'd0, idxA}, 64'd20);
    randomBlocks();
    doLoad(1'b1);
    check(idxA == 0 && idxB == 0, "R9 restart idx", {50'd0, idxA, idxB}, 64'd0);
    runRounds(20);

    // Reload after done clears done (R9)
    randomBlocks();
    doLoad(1'b0);
    check(!doneA && !doneB, "R9 done cleared", {62'd0, doneA, doneB}, 64'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule